// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags and Break Recovery

This block recovers words from an asynchronous serial line. A divisor-driven tick generator produces sixteen ticks per bit. A frame state machine confirms each start bit at its midpoint, samples data, parity and stop levels at mid-bit, and pushes every finished word into a four-entry receive queue. Each queued word carries its own framing-error and parity-error flags. Because the flags travel with the word, the head of the queue always shows the flags of the word being read.

Four frame formats are supported: 8 data bits with no, even or odd parity, or 9 data bits with no parity. Either one or two stop bits can be used. A line held low (a break) ends up as one all-zero word with the framing flag set. Reception then resumes only after the line has returned high. An address mode for 9-bit traffic interrupts on every word whose top bit is set. A loopback switch feeds the receiver from the internal transmit serial signal instead of the external pin.

The state machine has seven states:
- IDLE: waiting for a low line. A low line moves it to START.
- START: counting to the mid-start tick. A low sample there moves it to DATA; a high sample returns it to IDLE.
- DATA: one mid-bit sample per bit. After the last data bit it moves to PARITY in the parity formats, and to STOP1 otherwise.
- PARITY: samples the parity bit, then moves to STOP1.
- STOP1: samples the first stop level. With two stop bits it moves to STOP2. With one stop bit it pushes the word and moves to IDLE, or to WAIT_HIGH on a framing error.
- STOP2: samples the second stop level, pushes the word, and moves to IDLE, or to WAIT_HIGH on a framing error.
- WAIT_HIGH: holds until the line reads high, then moves to IDLE.

Top module: `uart_rx_core`

## Requirements
- R1: One bit lasts 16*(divisor+1) clock cycles. The divisor is a 16-bit input, 0 to 65535, and frames sent at that bit length are received correctly at more than one divisor value.
- R2: frame_fmt selects the format: 00 = 8 data bits, no parity; 01 = 8 bits, even parity; 10 = 8 bits, odd parity; 11 = 9 bits, no parity. stop2_en=1 selects two stop bits. Data arrives LSB first, and rd_word[8] reads 0 in the 8-bit formats.
- R3: rd_ferr is 1 for a word whose stop level sampled 0. With two stop bits, a 0 on either stop level sets it.
- R4: rd_perr is 1 when the total count of ones over the 8 data bits and the parity bit is odd in even mode, or even in odd mode. rd_perr is never 1 in formats 00 and 11.
- R5: After reset the queue is empty (data_avail=0), rd_ferr=0, rd_perr=0, overrun=0, irq=0 and idle=1. Every popped word presents its own data and flags in arrival order.
- R6: idle is 0 from start detection until the final stop sample, and 1 from then until the next start.
- R7: A line held low for 20 bit times yields exactly one word: data 0 with rd_ferr=1, at the frame length. idle is 1 while the line is still low, and no further word arrives until the line has gone high.
- R8: The queue holds 4 words. A word arriving when the queue is full and not being popped is dropped, and overrun is set and stays 1 until reset.
- R9: With irq_mode=0, irq pulses for one cycle on every received word. With irq_mode=1, it pulses only when the queue already holds at least 2 words as the word arrives, so that 3 of 4 entries are then filled.
- R10: With addr_mode_en=1 and frame_fmt=11, irq pulses exactly for words whose bit 8 is 1, whatever irq_mode is. With any other format, addr_mode_en has no effect.
- R11: With loopback_en=1 the receiver reads tx_loop, and activity on rx_pin produces no word.
- R12: A low pulse shorter than half a bit is rejected at the mid-start sample. No word is produced, and idle returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | External serial receive line |
| tx_loop | input | 1 | Internal transmit serial signal, used in loopback |
| loopback_en | input | 1 | Selects tx_loop as the receive source |
| divisor | input | 16 | Bit-rate divisor |
| frame_fmt | input | 2 | Data/parity format select |
| stop2_en | input | 1 | Two stop bits when 1 |
| addr_mode_en | input | 1 | Address-detect interrupt mode (9-bit format only) |
| irq_mode | input | 1 | 0: interrupt on every word, 1: interrupt at 3/4 full |
| pop | input | 1 | Removes the head word |
| rd_word | output | 9 | Head word data |
| rd_ferr | output | 1 | Framing flag of the head word |
| rd_perr | output | 1 | Parity flag of the head word |
| data_avail | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky word-dropped flag |
| idle | output | 1 | Receiver not inside a frame |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can meet in one clock cycle: a pop request and the arrival of a new word. The bench provokes this by holding pop high for a whole frame while one word is queued. The first pop empties the queue, and the later push then lands on a cycle where pop is still requested against an empty queue. The behavioural queue model shows that the new word is neither lost nor duplicated, by comparing the head on every clock and checking that exactly two words were removed. Break completion is also judged against a line that stays low, to show that no second word is started.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       perr;
        logic [8:0] data;
    } rx_word_t;

    localparam logic [1:0] FMT_8N = 2'b00;
    localparam logic [1:0] FMT_8E = 2'b01;
    localparam logic [1:0] FMT_8O = 2'b10;
    localparam logic [1:0] FMT_9N = 2'b11;

    localparam int TICKS_PER_BIT = 16;

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // one tick every divisor+1 clocks; >= keeps a lowered divisor from wrapping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] frame_fmt,
    input  logic      stop2_en,
    output logic      push,
    output rx_word_t  push_word,
    output logic      idle,
    output rx_state_e state_o
);
    localparam int TCNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [TCNT_W-1:0] MID_TICK = TCNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [TCNT_W-1:0] END_TICK = TCNT_W'(TICKS_PER_BIT - 1);

    rx_state_e          state, state_nx;
    logic [TCNT_W-1:0]  tcnt;
    logic [3:0]         bidx;
    logic [8:0]         shreg;
    logic               pbit;
    logic               ferr_acc;

    logic               is9, has_par, odd_mode, samp, mid_samp;
    logic [3:0]         last_idx;
    logic               perr_calc;

    assign is9       = (frame_fmt == FMT_9N);
    assign has_par   = (frame_fmt == FMT_8E) || (frame_fmt == FMT_8O);
    assign odd_mode  = (frame_fmt == FMT_8O);
    assign last_idx  = is9 ? 4'd8 : 4'd7;
    assign samp      = tick && (tcnt == END_TICK);
    assign mid_samp  = tick && (tcnt == MID_TICK);
    assign perr_calc = has_par && ((^shreg[7:0]) ^ pbit ^ odd_mode);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (!rx) state_nx = ST_START;
            ST_START:     if (mid_samp) state_nx = rx ? ST_IDLE : ST_DATA;
            ST_DATA:      if (samp && bidx == last_idx)
                              state_nx = has_par ? ST_PARITY : ST_STOP1;
            ST_PARITY:    if (samp) state_nx = ST_STOP1;
            ST_STOP1:     if (samp) begin
                              if (stop2_en)  state_nx = ST_STOP2;
                              else if (rx)   state_nx = ST_IDLE;
                              else           state_nx = ST_WAIT_HIGH;
                          end
            ST_STOP2:     if (samp) state_nx = (ferr_acc || !rx) ? ST_WAIT_HIGH : ST_IDLE;
            ST_WAIT_HIGH: if (rx) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            ferr_acc  <= 1'b0;
            push      <= 1'b0;
            push_word <= '0;
        end else begin
            push <= 1'b0;
            if (state == ST_IDLE || state == ST_WAIT_HIGH) begin
                tcnt <= '0;
            end else if (tick) begin
                tcnt <= (state == ST_START && tcnt == MID_TICK) ? '0 : tcnt + 1'b1;
            end
            unique case (state)
                ST_START: if (mid_samp && !rx) begin
                    bidx     <= '0;
                    shreg    <= '0;
                    pbit     <= 1'b0;
                    ferr_acc <= 1'b0;
                end
                ST_DATA: if (samp) begin
                    shreg[bidx] <= rx;
                    bidx        <= bidx + 1'b1;
                end
                ST_PARITY: if (samp) pbit <= rx;
                ST_STOP1: if (samp) begin
                    ferr_acc <= !rx;
                    if (!stop2_en) begin
                        push      <= 1'b1;
                        push_word <= '{ferr: !rx, perr: perr_calc, data: shreg};
                    end
                end
                ST_STOP2: if (samp) begin
                    push      <= 1'b1;
                    push_word <= '{ferr: ferr_acc | !rx, perr: perr_calc, data: shreg};
                end
                default: ;
            endcase
        end
    end

    assign idle    = (state == ST_IDLE) || (state == ST_WAIT_HIGH);
    assign state_o = state;
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import rx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rx_word_t         wdata,
    input  logic             pop,
    output rx_word_t         head,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    rx_word_t         mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             full, do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= wdata;
                wptr      <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && !do_push) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pin,
    input  logic             tx_loop,
    input  logic             loopback_en,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       frame_fmt,
    input  logic             stop2_en,
    input  logic             addr_mode_en,
    input  logic             irq_mode,
    input  logic             pop,
    output logic [8:0]       rd_word,
    output logic             rd_ferr,
    output logic             rd_perr,
    output logic             data_avail,
    output logic             overrun,
    output logic             idle,
    output logic             irq
);
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
    localparam int THRESH    = (FIFO_DEPTH * 3) / 4;
    localparam logic [CNT_W-1:0] IRQ_LVL = CNT_W'(THRESH - 1);

    logic                 line_sel, rx_s, tick, push, fifo_empty, addr_mode, irq_d;
    logic [SYNC_STAGES-1:0] sync_q;
    rx_word_t             push_word, head;
    rx_state_e            fsm_state;
    logic [CNT_W-1:0]     fifo_cnt;

    assign line_sel = loopback_en ? tx_loop : rx_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_sel};
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    rx_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx        (rx_s),
        .frame_fmt (frame_fmt),
        .stop2_en  (stop2_en),
        .push      (push),
        .push_word (push_word),
        .idle      (idle),
        .state_o   (fsm_state)
    );

    rx_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (push_word),
        .pop     (pop),
        .head    (head),
        .empty   (fifo_empty),
        .count   (fifo_cnt),
        .overrun (overrun)
    );

    assign addr_mode = addr_mode_en && (frame_fmt == FMT_9N);
    assign irq_d = push && (addr_mode ? push_word.data[8]
                                      : (!irq_mode || (fifo_cnt >= IRQ_LVL)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    assign rd_word    = head.data;
    assign rd_ferr    = head.ferr;
    assign rd_perr    = head.perr;
    assign data_avail = !fifo_empty;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
    import rx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input rx_state_e        state,
    input logic             rx_s,
    input logic             push,
    input rx_word_t         push_word,
    input logic [1:0]       frame_fmt,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             overrun,
    input logic             irq,
    input logic             data_avail,
    input logic             idle
);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_perr_parity_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word.perr) |-> (frame_fmt == FMT_8E || frame_fmt == FMT_8O));

    assert_break_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HIGH && !rx_s) |=> (state == ST_WAIT_HIGH));

    assert_irq_has_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> data_avail);

    assert_idle_fall_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> !$past(rx_s));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_state),
    .rx_s       (rx_s),
    .push       (push),
    .push_word  (push_word),
    .frame_fmt  (frame_fmt),
    .fifo_cnt   (fifo_cnt),
    .overrun    (overrun),
    .irq        (irq),
    .data_avail (data_avail),
    .idle       (idle)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pin = 1'b1, tx_loop = 1'b1, loopback_en = 1'b0;
    logic [15:0] divisor = 16'd2;
    logic [1:0]  frame_fmt = 2'b00;
    logic        stop2_en = 1'b0, addr_mode_en = 1'b0, irq_mode = 1'b0, pop = 1'b0;
    logic [8:0]  rd_word;
    logic        rd_ferr, rd_perr, data_avail, overrun, idle, irq;

    int checks = 0, failures = 0;
    int irq_seen = 0, exp_irq = 0;
    bit exp_overrun = 0;
    logic [10:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loopback_en(loopback_en), .divisor(divisor), .frame_fmt(frame_fmt),
        .stop2_en(stop2_en), .addr_mode_en(addr_mode_en), .irq_mode(irq_mode),
        .pop(pop), .rd_word(rd_word), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
        .data_avail(data_avail), .overrun(overrun), .idle(idle), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // per-clock comparison of the queue head with the model (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (data_avail) begin
                if (mq.size() == 0)
                    chk(0, "R5", "unexpected word", {rd_ferr, rd_perr, rd_word}, 0);
                else
                    chk({rd_ferr, rd_perr, rd_word} == mq[0], "R5", "head word",
                        {rd_ferr, rd_perr, rd_word}, mq[0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    function automatic int bitc();
        return 16 * (int'(divisor) + 1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        mq.delete();
        exp_overrun = 0;
        repeat (3) @(negedge clk);
        irq_seen = 0;
        exp_irq = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive(input logic v);
        if (loopback_en) tx_loop = v; else rx_pin = v;
        repeat (bitc()) @(negedge clk);
    endtask

    task automatic model_push(input logic [10:0] w);
        if (addr_mode_en && frame_fmt == 2'b11) exp_irq += int'(w[8]);
        else if (!irq_mode || mq.size() >= 2)   exp_irq += 1;
        if (mq.size() == 4) exp_overrun = 1;
        else mq.push_back(w);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par,
                              input bit bad_s1, input bit bad_s2);
        int nb = (frame_fmt == 2'b11) ? 9 : 8;
        bit hp = (frame_fmt == 2'b01) || (frame_fmt == 2'b10);
        logic par = (^d[7:0]) ^ (frame_fmt == 2'b10) ^ bad_par;
        logic [8:0] ed = (nb == 9) ? d : {1'b0, d[7:0]};
        logic [10:0] w = {bad_s1 | (stop2_en & bad_s2), hp & bad_par, ed};
        drive(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == 1) chk(idle == 1'b0, "R6", "idle mid-frame", idle, 0);
            drive(d[i]);
        end
        if (hp) drive(par);
        if (stop2_en) begin
            drive(!bad_s1);
            model_push(w);
            drive(!bad_s2);
        end else begin
            model_push(w);
            drive(!bad_s1);
        end
        drive(1'b1);
        chk(idle == 1'b1, "R6", "idle after frame", idle, 1);
    endtask

    task automatic pop_one();
        @(negedge clk);
        pop = 1'b1;
        @(posedge clk);
        #1;
        pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic drain(input int exp_n, input string req);
        int n = 0;
        @(negedge clk);
        while (data_avail && n < 8) begin
            pop_one();
            n++;
            @(negedge clk);
        end
        chk(n == exp_n, req, "words drained", n, exp_n);
        chk(mq.size() == 0, req, "model left", mq.size(), 0);
    endtask

    task automatic settle(input string req);
        chk(irq_seen == exp_irq, req, "irq count", irq_seen, exp_irq);
        chk(overrun == exp_overrun, req, "overrun", overrun, exp_overrun);
    endtask

    initial begin
        do_reset();
        // R5: reset state
        chk(data_avail == 0, "R5", "reset data_avail", data_avail, 0);
        chk(idle == 1, "R5", "reset idle", idle, 1);
        chk(overrun == 0 && irq == 0, "R5", "reset overrun/irq", {overrun, irq}, 0);
        chk(rd_ferr == 0 && rd_perr == 0, "R5", "reset flags", {rd_ferr, rd_perr}, 0);

        // R1 R2: 8N1 at divisor 2
        send_frame(9'h0A5, 0, 0, 0);
        send_frame(9'h03C, 0, 0, 0);
        settle("R2");
        drain(2, "R1");

        // R4: even and odd parity, good and bad
        frame_fmt = 2'b01;
        send_frame(9'h05A, 0, 0, 0);
        send_frame(9'h05A, 1, 0, 0);
        drain(2, "R4");
        frame_fmt = 2'b10;
        send_frame(9'h081, 0, 0, 0);
        send_frame(9'h081, 1, 0, 0);
        drain(2, "R4");

        // R2: 9 data bits, two stop bits; bad_par has no meaning here (R4)
        frame_fmt = 2'b11;
        stop2_en = 1'b1;
        send_frame(9'h1FE, 1, 0, 0);
        send_frame(9'h0AB, 0, 0, 0);
        drain(2, "R2");

        // R3: framing errors
        send_frame(9'h133, 0, 0, 1);
        send_frame(9'h0CC, 0, 1, 0);
        frame_fmt = 2'b00;
        stop2_en = 1'b0;
        send_frame(9'h0F0, 0, 1, 0);
        drain(3, "R3");
        settle("R3");

        // R1: divisor 0
        divisor = 16'd0;
        send_frame(9'h069, 0, 0, 0);
        drain(1, "R1");
        divisor = 16'd2;
        repeat (10) @(negedge clk);

        // R7: 20-bit break
        for (int i = 0; i < 20; i++) begin
            if (i == 9) model_push(11'h400);
            if (i == 15) begin
                chk(idle == 1, "R7", "idle during break", idle, 1);
                chk(data_avail == 1 && rd_ferr == 1 && rd_word == 0, "R7", "break word",
                    {data_avail, rd_ferr, rd_word}, 11'h600);
            end
            drive(1'b0);
        end
        drive(1'b1);
        drive(1'b1);
        drain(1, "R7");

        // R12: short low pulse
        rx_pin = 1'b0;
        repeat (6) @(negedge clk);
        rx_pin = 1'b1;
        repeat (3 * bitc()) @(negedge clk);
        chk(data_avail == 0, "R12", "glitch word", data_avail, 0);
        chk(idle == 1, "R12", "glitch idle", idle, 1);
        settle("R12");

        // R8: overrun
        for (int i = 0; i < 5; i++) send_frame(9'(8'h10 + i), 0, 0, 0);
        settle("R8");
        chk(overrun == 1, "R8", "overrun set", overrun, 1);
        drain(4, "R8");
        chk(overrun == 1, "R8", "overrun stays", overrun, 1);

        // R9: interrupt at 3/4 full
        do_reset();
        irq_mode = 1'b1;
        for (int i = 0; i < 4; i++) send_frame(9'(8'h20 + i), 0, 0, 0);
        chk(irq_seen == 2, "R9", "3/4 irq count", irq_seen, 2);
        drain(4, "R9");
        irq_mode = 1'b0;
        send_frame(9'h055, 0, 0, 0);
        send_frame(9'h0AA, 0, 0, 0);
        settle("R9");
        drain(2, "R9");

        // R10: address mode
        do_reset();
        frame_fmt = 2'b11;
        addr_mode_en = 1'b1;
        send_frame(9'h155, 0, 0, 0);
        send_frame(9'h055, 0, 0, 0);
        send_frame(9'h1AA, 0, 0, 0);
        chk(irq_seen == 2, "R10", "address irq count", irq_seen, 2);
        drain(3, "R10");
        frame_fmt = 2'b00;
        send_frame(9'h011, 0, 0, 0);
        settle("R10");
        drain(1, "R10");
        addr_mode_en = 1'b0;

        // R11: loopback, rx_pin held low must be ignored
        loopback_en = 1'b1;
        rx_pin = 1'b0;
        send_frame(9'h0C3, 0, 0, 0);
        repeat (2 * bitc()) @(negedge clk);
        drain(1, "R11");
        rx_pin = 1'b1;
        repeat (4) @(negedge clk);
        loopback_en = 1'b0;

        // coincidence: pop held through a push onto an empty queue (R8 R5)
        send_frame(9'h07E, 0, 0, 0);
        begin
            int pops = 0;
            fork
                send_frame(9'h0E7, 0, 0, 0);
                begin
                    for (int c = 0; c < 12 * bitc(); c++) begin
                        bit av;
                        @(negedge clk);
                        pop = 1'b1;
                        av = data_avail;
                        @(posedge clk);
                        #1;
                        if (av) begin
                            void'(mq.pop_front());
                            pops++;
                        end
                    end
                    pop = 1'b0;
                end
            join
            chk(pops == 2, "R8", "words through held pop", pops, 2);
            chk(mq.size() == 0 && data_avail == 0, "R5", "queue empty", data_avail, 0);
        end

        finish_run();
    end
endmodule